// File: doc/BRIEF.md
# Delayed Write Retry Matcher

This block sits on the initiator side of a bridge and holds pending delayed writes in a small in-order queue. An initiator that was told to retry comes back later with the same write. The block compares each retry against the oldest pending entry only. The compare covers four fields: address, command, data and byte enables. The parity bit of the retry plays no part in the decision.

The target side reports when the oldest entry has finished on the far bus. From then on, a matching retry completes the write: the block pulses a completion indication and removes the entry. If no matching retry arrives within a programmable number of cycles after that report, the block gives up. It discards the entry and raises a one-cycle system error pulse.

All indications are registered. A retry presented in one cycle is answered in the following cycle.

Top module: `dwm_match_top`

## Requirements
- R1: After reset the queue reads empty (`q_empty`=1, `q_full`=0) and `match_o`, `nomatch_o`, `complete_o` and `serr_o` are all low.
- R2: A write offered on `enq_valid` is stored when the queue is not full. The queue holds DEPTH entries, and `q_full` is high when it holds all of them. An offer made while the queue is full is dropped and never becomes visible.
- R3: A strobe on `retry_strobe` while the queue is non-empty produces exactly one of `match_o` or `nomatch_o` in the next cycle. `match_o` is given only when address, command, every data byte and byte enables all equal the oldest entry.
- R4: The value of `retry_par` never changes the match decision.
- R5: Only the oldest entry is compared. A retry equal to a younger entry yields `nomatch_o`.
- R6: A strobe while the queue is empty yields neither `match_o` nor `nomatch_o`.
- R7: A matching retry completes the entry only if the oldest entry has been marked finished. When it completes, `complete_o` rises in the same cycle as `match_o` and the entry leaves the queue. A match without the finished mark leaves the queue unchanged.
- R8: A `tgt_done` pulse marks the oldest entry finished. The pulse is ignored while the queue is empty.
- R9: If an entry stays marked finished for TMO_CYCLES cycles without completing, it is discarded and `serr_o` is high for exactly one cycle. The count restarts from zero for every new oldest entry.
- R10: Entries leave in arrival order. After a removal, the next-oldest entry becomes the one compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer a new delayed write to the queue |
| enq_addr | input | ADDR_W | Address of offered write |
| enq_cmd | input | CMD_W | Command of offered write |
| enq_data | input | DATA_W | Data of offered write |
| enq_be | input | BE_W | Byte enables of offered write |
| tgt_done | input | 1 | Far-side completion report for the oldest entry |
| retry_strobe | input | 1 | Initiator retry is present this cycle |
| retry_addr | input | ADDR_W | Retry address |
| retry_cmd | input | CMD_W | Retry command |
| retry_data | input | DATA_W | Retry data |
| retry_be | input | BE_W | Retry byte enables |
| retry_par | input | 1 | Retry parity bit (not compared) |
| match_o | output | 1 | Previous-cycle retry equalled the oldest entry |
| nomatch_o | output | 1 | Previous-cycle retry differed from the oldest entry |
| complete_o | output | 1 | Oldest entry was completed and removed |
| serr_o | output | 1 | Timeout discarded the oldest entry |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds DEPTH entries |

## Verification
The checker watches several properties on every cycle:
- `match_o` and `nomatch_o` are never both high.
- Every strobe on a non-empty queue gets an answer, and no answer appears without a strobe.
- A strobe on an empty queue is silent.
- Completion never occurs without a match, and never in the same cycle as a timeout error.
- The error pulse lasts one cycle.

Other behaviours only the directed scenarios can show:
- Which field mismatches lead to `nomatch_o`.
- That parity is ignored.
- That younger entries are not compared.
- Arrival order.
- That an offer made while the queue is full disappears.
- The exact cycle count to timeout, and that the count restarts for the next entry.

// File: rtl/dwm_pkg.sv
package dwm_pkg;

    parameter int ADDR_W = 32;
    parameter int CMD_W  = 4;
    parameter int DATA_W = 32;
    parameter int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } dw_entry_t;

    localparam int ENTRY_W = $bits(dw_entry_t);

    function automatic dw_entry_t pack_entry(
        input logic [ADDR_W-1:0] a,
        input logic [CMD_W-1:0]  c,
        input logic [DATA_W-1:0] d,
        input logic [BE_W-1:0]   b
    );
        dw_entry_t e;
        e.addr = a;
        e.cmd  = c;
        e.data = d;
        e.be   = b;
        return e;
    endfunction

endpackage

// File: rtl/dwm_fifo.sv
module dwm_fifo
    import dwm_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  dw_entry_t din,
    input  logic      pop,
    output dw_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    dw_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    assign empty = (fill == '0);
    assign full  = (fill == CNT_W'(DEPTH));
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/dwm_compare.sv
module dwm_compare
    import dwm_pkg::*;
(
    input  dw_entry_t held,
    input  dw_entry_t probe,
    output logic      same
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_same;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_same[g] = (held.data[g*8 +: 8] == probe.data[g*8 +: 8]);
    end

    logic hdr_same;
    assign hdr_same = (held.addr == probe.addr) &&
                      (held.cmd  == probe.cmd)  &&
                      (held.be   == probe.be);

    assign same = hdr_same && (&lane_same);

endmodule

// File: rtl/dwm_timeout.sv
module dwm_timeout #(
    parameter int TMO_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic expire
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dwm_match_top.sv
module dwm_match_top
    import dwm_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int TMO_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [CMD_W-1:0]  enq_cmd,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [BE_W-1:0]   enq_be,
    input  logic              tgt_done,
    input  logic              retry_strobe,
    input  logic [ADDR_W-1:0] retry_addr,
    input  logic [CMD_W-1:0]  retry_cmd,
    input  logic [DATA_W-1:0] retry_data,
    input  logic [BE_W-1:0]   retry_be,
    input  logic              retry_par,
    output logic              match_o,
    output logic              nomatch_o,
    output logic              complete_o,
    output logic              serr_o,
    output logic              q_empty,
    output logic              q_full
);
    dw_entry_t head_e, probe_e, new_e;
    logic      same, head_valid, done_q;
    logic      hit, miss, complete_now, tmo_expire, discard_now, pop;

    assign new_e   = pack_entry(enq_addr, enq_cmd, enq_data, enq_be);
    assign probe_e = pack_entry(retry_addr, retry_cmd, retry_data, retry_be);

    dwm_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (enq_valid),
        .din   (new_e),
        .pop   (pop),
        .head  (head_e),
        .empty (q_empty),
        .full  (q_full)
    );

    dwm_compare u_cmp (
        .held  (head_e),
        .probe (probe_e),
        .same  (same)
    );

    dwm_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .run    (done_q),
        .clr    (pop),
        .expire (tmo_expire)
    );

    // retry_par is deliberately left out of the decision
    logic par_unused;
    assign par_unused = retry_par;

    assign head_valid   = !q_empty;
    assign hit          = retry_strobe && head_valid && same;
    assign miss         = retry_strobe && head_valid && !same;
    assign complete_now = hit && done_q;
    assign discard_now  = tmo_expire && !complete_now;
    assign pop          = complete_now || discard_now;

    always_ff @(posedge clk) begin
        if (rst || pop) begin
            done_q <= 1'b0;
        end else if (tgt_done && head_valid) begin
            done_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_o    <= 1'b0;
            nomatch_o  <= 1'b0;
            complete_o <= 1'b0;
            serr_o     <= 1'b0;
        end else begin
            match_o    <= hit;
            nomatch_o  <= miss;
            complete_o <= complete_now;
            serr_o     <= discard_now;
        end
    end

endmodule

// File: rtl/dwm_match_chk.sv
module dwm_match_chk (
    input logic clk,
    input logic rst,
    input logic retry_strobe,
    input logic match_o,
    input logic nomatch_o,
    input logic complete_o,
    input logic serr_o,
    input logic q_empty,
    input logic q_full
);
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        !(match_o && nomatch_o));                                          // R3
    AST_ANSWER_GIVEN: assert property (@(posedge clk) disable iff (rst)
        (retry_strobe && !q_empty) |=> (match_o || nomatch_o));            // R3
    AST_NO_UNASKED: assert property (@(posedge clk) disable iff (rst)
        (match_o || nomatch_o) |-> $past(retry_strobe));                   // R3
    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (retry_strobe && q_empty) |=> !(match_o || nomatch_o));            // R6
    AST_DONE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        complete_o |-> match_o);                                           // R7
    AST_SERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        serr_o |=> !serr_o);                                               // R9
    AST_SERR_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        serr_o |-> !(complete_o || match_o));                              // R9
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        q_full |-> !q_empty);                                              // R2
endmodule

bind dwm_match_top dwm_match_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .retry_strobe (retry_strobe),
    .match_o      (match_o),
    .nomatch_o    (nomatch_o),
    .complete_o   (complete_o),
    .serr_o       (serr_o),
    .q_empty      (q_empty),
    .q_full       (q_full)
);

// File: tb/dwm_match_top_tb.sv
module dwm_match_top_tb;
    import dwm_pkg::*;

    localparam int DEPTH = 4;
    localparam int TMO   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enq_valid = 1'b0, tgt_done = 1'b0, retry_strobe = 1'b0, retry_par = 1'b0;
    logic [ADDR_W-1:0] enq_addr = '0, retry_addr = '0;
    logic [CMD_W-1:0]  enq_cmd = '0, retry_cmd = '0;
    logic [DATA_W-1:0] enq_data = '0, retry_data = '0;
    logic [BE_W-1:0]   enq_be = '0, retry_be = '0;
    logic match_o, nomatch_o, complete_o, serr_o, q_empty, q_full;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dwm_match_top #(.DEPTH(DEPTH), .TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_cmd(enq_cmd),
        .enq_data(enq_data), .enq_be(enq_be), .tgt_done(tgt_done),
        .retry_strobe(retry_strobe), .retry_addr(retry_addr), .retry_cmd(retry_cmd),
        .retry_data(retry_data), .retry_be(retry_be), .retry_par(retry_par),
        .match_o(match_o), .nomatch_o(nomatch_o), .complete_o(complete_o),
        .serr_o(serr_o), .q_empty(q_empty), .q_full(q_full)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic dw_entry_t mk(int n);
        return pack_entry(ADDR_W'(32'h1000_0000 + n * 16), CMD_W'(4'h7),
                          DATA_W'(32'hA5A5_0000 + n), BE_W'(4'hF));
    endfunction

    task automatic enq(dw_entry_t e);
        @(negedge clk);
        enq_valid = 1'b1;
        enq_addr = e.addr; enq_cmd = e.cmd; enq_data = e.data; enq_be = e.be;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        tgt_done = 1'b1;
        @(negedge clk);
        tgt_done = 1'b0;
    endtask

    task automatic retry(string req, dw_entry_t e, logic par, int em, int en, int ec);
        @(negedge clk);
        retry_strobe = 1'b1; retry_par = par;
        retry_addr = e.addr; retry_cmd = e.cmd; retry_data = e.data; retry_be = e.be;
        @(negedge clk);
        retry_strobe = 1'b0;
        check(req, "match_o", int'(match_o), em);
        check(req, "nomatch_o", int'(nomatch_o), en);
        check(req, "complete_o", int'(complete_o), ec);
    endtask

    task automatic t_reset();
        check("R1", "q_empty", int'(q_empty), 1);
        check("R1", "q_full", int'(q_full), 0);
        check("R1", "outputs", int'({match_o, nomatch_o, complete_o, serr_o}), 0);
    endtask

    task automatic t_empty_strobe();
        retry("R6", mk(0), 1'b0, 0, 0, 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH; i++) enq(mk(i));
        check("R2", "q_full", int'(q_full), 1);
        enq(mk(9));   // dropped: queue full
        check("R2", "q_full after drop", int'(q_full), 1);
    endtask

    task automatic t_fields();
        dw_entry_t e;
        retry("R7", mk(0), 1'b0, 1, 0, 0);       // match but not finished
        check("R7", "q_full kept", int'(q_full), 1);
        e = mk(0); e.addr[5] = ~e.addr[5];
        retry("R3", e, 1'b0, 0, 1, 0);
        e = mk(0); e.cmd[0] = ~e.cmd[0];
        retry("R3", e, 1'b0, 0, 1, 0);
        e = mk(0); e.data[DATA_W-1] = ~e.data[DATA_W-1];
        retry("R3", e, 1'b0, 0, 1, 0);
        e = mk(0); e.be[1] = 1'b0;
        retry("R3", e, 1'b0, 0, 1, 0);
        retry("R4", mk(0), 1'b1, 1, 0, 0);
        retry("R4", mk(0), 1'b0, 1, 0, 0);
        retry("R5", mk(1), 1'b0, 0, 1, 0);
    endtask

    task automatic t_complete();
        done_pulse();
        retry("R7", mk(0), 1'b1, 1, 0, 1);
        check("R7", "q_full after pop", int'(q_full), 0);
        retry("R10", mk(0), 1'b0, 0, 1, 0);
        retry("R10", mk(1), 1'b0, 1, 0, 0);
    endtask

    task automatic t_timeout();
        int n = 0;
        int width = 0;
        done_pulse();
        while (n < TMO + 8 && !serr_o) begin
            @(negedge clk);
            n++;
        end
        check("R9", "cycles to serr", n, TMO);
        while (serr_o) begin
            width++;
            @(negedge clk);
        end
        check("R9", "serr width", width, 1);
        retry("R10", mk(2), 1'b0, 1, 0, 0);
    endtask

    task automatic t_restart();
        int n = 0;
        done_pulse();
        repeat (10) @(negedge clk);
        retry("R7", mk(2), 1'b0, 1, 0, 1);
        done_pulse();
        while (n < TMO + 8 && !serr_o) begin
            @(negedge clk);
            n++;
        end
        check("R9", "restart cycles to serr", n, TMO);
        @(negedge clk);
        check("R2", "dropped entry absent", int'(q_empty), 1);
    endtask

    task automatic t_done_empty();
        int seen = 0;
        done_pulse();
        enq(mk(5));
        repeat (TMO + 6) begin
            @(negedge clk);
            if (serr_o) seen++;
        end
        check("R8", "serr after done on empty", seen, 0);
        retry("R8", mk(5), 1'b0, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty_strobe();
        t_fill();
        t_fields();
        t_complete();
        t_timeout();
        t_restart();
        t_done_empty();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule